// File: doc/BRIEF.md
# Set-Selectable Cyclic Pattern Serializer

This block sends a repeating bit pattern without end. The pattern is drawn from a bank of 32 stored patterns. Each pattern is eight 16-bit words, 128 bits in all. A position counter steps through the pattern and never stops. It is made of a 3-bit word index and a 4-bit bit index. An external 5-bit set number picks which pattern is read. The set number can change at any moment. A change never touches the position counter, so the stream carries on at the same word and bit, now taken from the new pattern.

There are two outputs. `word_o` gives the current 16-bit word. `bit_o` gives the serial stream, most significant bit first. `word_start_o` marks the first bit of each word, which is also the point where `word_o` can be sampled. The bank comes out of reset with computed contents. A write port can reload it while the block runs. A consumer can pace the stream through `en_i`.

Top module: `pattern_serializer`

## Requirements
- R1: While `rst_ni` is low, the block is at word index 0 and bit index 15 of set 0. `word_start_o` is 1 and `word_o` shows the word at address 0.
- R2: After reset, the word at bank address a (8 bits) is {a, ~a}. The address in the upper byte, its inverse in the lower byte.
- R3: `bit_o` equals `word_o[k]`, where k is the current bit index. On each enabled clock, k counts down from 15 to 0, so each word goes out MSB first.
- R4: `word_start_o` is 1 exactly when the bit index is 15. With `en_i` held high, that is one cycle in every 16.
- R5: After bit 0 of word 7, the stream moves to bit 15 of word 0. The 128-bit pattern repeats with no inserted bits.
- R6: A value on `set_sel_i` sampled at a clock edge chooses the data shown after that edge. That is one clock of latency, fixed.
- R7: A set change, at any position including mid-word, leaves the word and bit indices unchanged. The next output bit comes from the same position in the new pattern.
- R8: While `en_i` is low, the word and bit indices hold. With set and bank unchanged, all outputs hold.
- R9: A write with `wr_en_i` high stores `wr_data_i` at `wr_addr_i` at the clock edge. If that word is being read, the new value shows from the next cycle. Other addresses keep their contents.
- R10: The bank address read is {registered set, word index}: the set in bits 7:3 and the word index in bits 2:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Advance the position when high |
| set_sel_i | input | 5 | Pattern set number |
| wr_en_i | input | 1 | Bank write strobe |
| wr_addr_i | input | 8 | Bank write address {set, word} |
| wr_data_i | input | 16 | Bank write data |
| word_o | output | 16 | Current pattern word |
| bit_o | output | 1 | Serial output bit, MSB first |
| word_start_o | output | 1 | High on the first bit of each word |

## Verification
Position state is shared by every pattern. A word or bit index that drifts, slips at the wrap, or is cleared by a set change therefore shows on `bit_o` in the next cycle, and on `word_start_o` within 16 enabled cycles. A set register that is missing or doubled moves every switch by one cycle. Because each set's default contents differ at every address, that shift shows up on the first cycle after the switch. A bank write that lands on the wrong address, or one that arrives late, shows on `word_o` on the next visit to that word.

// File: rtl/ps_pkg.sv
package ps_pkg;
  localparam int unsigned SET_W_DEF  = 5;
  localparam int unsigned WIDX_W_DEF = 3;
  localparam int unsigned DATA_W_DEF = 16;

  // Default bank word: address in the high half, its inverse in the low half.
  function automatic logic [31:0] seed_word(input int unsigned addr, input int unsigned aw);
    logic [31:0] mask;
    mask = (32'd1 << aw) - 32'd1;
    return ((addr & mask) << aw) | (~addr & mask);
  endfunction
endpackage

// File: rtl/ps_bank.sv
module ps_bank #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= DATA_W'(ps_pkg::seed_word(i, ADDR_W));
    end else if (wr_en_i) begin
      mem_q[wr_addr_i] <= wr_data_i;
    end
  end

  assign rd_data_o = mem_q[rd_addr_i];

  // R9: a write is visible at its address on the following cycle
  a_r9_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && (rd_addr_i == wr_addr_i) |=> (rd_addr_i != $past(wr_addr_i)) || (rd_data_o == $past(wr_data_i)));
endmodule

// File: rtl/ps_position.sv
module ps_position #(
  parameter int unsigned WIDX_W = 3,
  parameter int unsigned BIDX_W = 4,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  output logic [WIDX_W-1:0] word_idx_o,
  output logic [BIDX_W-1:0] bit_idx_o
);
  localparam logic [BIDX_W-1:0] BIT_TOP  = BIDX_W'(DATA_W - 1);
  localparam logic [WIDX_W-1:0] WORD_TOP = '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_idx_o <= '0;
      bit_idx_o  <= BIT_TOP;
    end else if (en_i) begin
      if (bit_idx_o == '0) begin
        bit_idx_o  <= BIT_TOP;
        word_idx_o <= word_idx_o + 1'b1;
      end else begin
        bit_idx_o <= bit_idx_o - 1'b1;
      end
    end
  end

  // R5: last bit of last word wraps to the first bit of word 0
  a_r5_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && (word_idx_o == WORD_TOP) && (bit_idx_o == '0) |=> (word_idx_o == '0) && (bit_idx_o == BIT_TOP));

  // R8: disabled cycle holds the position
  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(word_idx_o) && $stable(bit_idx_o));
endmodule

// File: rtl/ps_tap.sv
module ps_tap #(
  parameter int unsigned BIDX_W = 4,
  parameter int unsigned DATA_W = 16
) (
  input  logic [DATA_W-1:0] word_i,
  input  logic [BIDX_W-1:0] bit_idx_i,
  output logic              bit_o,
  output logic              start_o
);
  assign bit_o   = word_i[bit_idx_i];
  assign start_o = (bit_idx_i == BIDX_W'(DATA_W - 1));
endmodule

// File: rtl/pattern_serializer.sv
module pattern_serializer #(
  parameter int unsigned SET_W  = ps_pkg::SET_W_DEF,
  parameter int unsigned WIDX_W = ps_pkg::WIDX_W_DEF,
  parameter int unsigned DATA_W = ps_pkg::DATA_W_DEF,
  localparam int unsigned ADDR_W = SET_W + WIDX_W,
  localparam int unsigned BIDX_W = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [SET_W-1:0]  set_sel_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] word_o,
  output logic              bit_o,
  output logic              word_start_o
);
  logic [SET_W-1:0]  set_q;
  logic [WIDX_W-1:0] word_idx;
  logic [BIDX_W-1:0] bit_idx;

  // Set number registered once; never touches the position counter.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) set_q <= '0;
    else         set_q <= set_sel_i;
  end

  ps_position #(.WIDX_W(WIDX_W), .BIDX_W(BIDX_W), .DATA_W(DATA_W)) u_pos (
    .clk_i, .rst_ni, .en_i,
    .word_idx_o (word_idx),
    .bit_idx_o  (bit_idx)
  );

  ps_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bank (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .rd_addr_i ({set_q, word_idx}),
    .rd_data_o (word_o)
  );

  ps_tap #(.BIDX_W(BIDX_W), .DATA_W(DATA_W)) u_tap (
    .word_i    (word_o),
    .bit_idx_i (bit_idx),
    .bit_o     (bit_o),
    .start_o   (word_start_o)
  );

  // R4: word marker is never high on two consecutive enabled cycles
  a_r4_start_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && word_start_o |=> !word_start_o);

  // R7: a set change alone leaves the position untouched
  a_r7_set_keeps_pos: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i && (set_sel_i != set_q) |=> $stable(word_idx) && $stable(bit_idx));
endmodule

// File: tb/pattern_serializer_tb.sv
module pattern_serializer_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_i = 1'b0;
  logic [4:0]  set_sel_i = '0;
  logic        wr_en_i = 1'b0;
  logic [7:0]  wr_addr_i = '0;
  logic [15:0] wr_data_i = '0;
  logic [15:0] word_o;
  logic        bit_o;
  logic        word_start_o;

  always #5 clk_i = ~clk_i;

  pattern_serializer dut_i (.*);

  typedef struct {
    logic [15:0] word;
    logic        b;
    logic        start;
    string       tag;
  } exp_t;

  exp_t        sb_q[$];
  int          n_checks = 0;
  int          n_errors = 0;
  bit          summary_done = 0;
  logic [15:0] m_bank [256];
  logic [4:0]  m_set;
  logic [2:0]  m_word;
  logic [3:0]  m_bit;

  task automatic report();
    if (!summary_done) begin
      summary_done = 1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  endtask

  task automatic chk(input string tag, input logic [15:0] aw, input logic ab, input logic as_,
                     input logic [15:0] ew, input logic eb, input logic es);
    n_checks++;
    if (aw !== ew || ab !== eb || as_ !== es) begin
      n_errors++;
      $display("FAIL %s: word=%h bit=%b start=%b expected word=%h bit=%b start=%b",
               tag, aw, ab, as_, ew, eb, es);
    end
  endtask

  // Monitor: compare design outputs against queued expectations.
  always @(negedge clk_i) begin
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      chk(e.tag, word_o, bit_o, word_start_o, e.word, e.b, e.start);
    end
  end

  // Driver: apply one cycle of stimulus and push the expected result.
  task automatic step(input logic [4:0] sel, input logic en, input logic we,
                      input logic [7:0] wa, input logic [15:0] wd, input string tag);
    exp_t e;
    set_sel_i = sel; en_i = en; wr_en_i = we; wr_addr_i = wa; wr_data_i = wd;
    @(posedge clk_i);
    if (we) m_bank[wa] = wd;          // R9
    m_set = sel;                      // R6
    if (en) begin                     // R3, R5
      if (m_bit == 0) begin m_bit = 4'd15; m_word = m_word + 3'd1; end
      else m_bit = m_bit - 4'd1;
    end
    e.word  = m_bank[{m_set, m_word}];   // R10
    e.b     = e.word[m_bit];
    e.start = (m_bit == 4'd15);          // R4
    e.tag   = tag;
    sb_q.push_back(e);
    @(negedge clk_i);
  endtask

  initial begin
    #(200000 * 10);
    n_checks++; n_errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    report();
  end

  initial begin
    for (int a = 0; a < 256; a++) m_bank[a] = {a[7:0], ~a[7:0]};   // R2
    m_set = 0; m_word = 0; m_bit = 4'd15;
    repeat (3) @(negedge clk_i);
    chk("R1 reset state", word_o, bit_o, word_start_o, 16'h00FF, 1'b0, 1'b1);
    rst_ni = 1'b1;

    // R3 R4 R5: two full periods of set 0 plus a bit
    for (int i = 0; i < 260; i++) step(5'd0, 1'b1, 1'b0, 8'd0, 16'd0, "R5 wrap/R3 order/R4 marker");
    // R2: default contents, walk several sets
    for (int s = 1; s < 32; s += 6)
      for (int i = 0; i < 128; i++) step(5'(s), 1'b1, 1'b0, 8'd0, 16'd0, "R2 default content");
    // R6 R7: switch set every few cycles, mid-word
    for (int i = 0; i < 200; i++) step(5'((i / 5) * 7), 1'b1, 1'b0, 8'd0, 16'd0, "R6/R7 set switch");
    // R8: enable pulsed, with set changes while frozen
    for (int i = 0; i < 120; i++) step(5'((i / 9) + 3), (i % 3) == 0, 1'b0, 8'd0, 16'd0, "R8 enable hold");
    // R9: overwrite all of set 4 while reading it, and set 9 (unread)
    for (int i = 0; i < 8; i++) step(5'd4, 1'b0, 1'b1, {5'd4, 3'(i)}, 16'hA500 + 16'(i), "R9 write");
    for (int i = 0; i < 8; i++) step(5'd4, 1'b0, 1'b1, {5'd9, 3'(i)}, 16'h5A00 + 16'(i), "R9 write other set");
    for (int i = 0; i < 160; i++) step(5'd4, 1'b1, 1'b0, 8'd0, 16'd0, "R9 readback");
    // R9: write to the word being read while running
    for (int i = 0; i < 40; i++) step(5'd9, 1'b1, 1'b1, {5'd9, m_word}, 16'hC3C3 ^ 16'(i * 37), "R9 live write");
    // R10: top set boundary
    for (int i = 0; i < 130; i++) step(5'd31, 1'b1, 1'b0, 8'd0, 16'd0, "R10 address top set");
    for (int i = 0; i < 20; i++) step(5'd0, 1'b1, 1'b0, 8'd0, 16'd0, "R10 address set 0");

    while (sb_q.size() > 0) @(negedge clk_i);
    @(negedge clk_i);
    report();
  end
endmodule